// File: doc/BRIEF.md
# Fragment Program Instruction Fetch Sequencer

The sequencer walks a fragment program held in word-addressed memory and hands each instruction to an execute stage as one decoded bundle, using a valid/ready handshake. An instruction spans four consecutive 32-bit words. The first word holds the operation code, the destination register with its component write mask, and the selector for the single interpolated input. The next three words are the operand selectors for sources 0, 1 and 2. Any source selector can mark an operand as an inline constant. In that case the four words that follow the instruction form a vec4 constant. The sequencer returns the constant with the bundle and starts the next fetch past it.

The sequencer runs one level of counted repeat loops itself. Loop-begin and loop-end instructions are consumed inside the block and never reach the bundle port. While fetching, it also keeps a flag for the whole program that tells downstream configuration whether any instruction writes the depth result. A start pulse fetches the program from address 0. The sequencer then runs until it accepts an instruction with the end bit set, raises done, and waits for the next start.

Top module: `frag_fetch_seq`

## Requirements
- R1: While reset is held and after it is released, `bundle_valid`, `done` and `mem_rd_en` are 0 and `depth_cfg` is 1.
- R2: An ordinary instruction at address A is read from A..A+3. Bundle fields come from word A as follows: opcode bits [5:0], destination register bits [10:6], write mask bits [14:11] (bit 11 = x, bit 13 = z), input selector bits [18:15]. `out_src0`, `out_src1` and `out_src2` are words A+1, A+2 and A+3. Bundles appear in program execution order.
- R3: When bits [1:0] of any source word equal 2'b10, the instruction has an inline constant. Words A+4..A+7 then appear on `out_const`, with word A+4+k in bits [32k+31:32k], and `out_const_valid` is 1. The next instruction starts at A+8. Without a constant, `out_const` is zero, `out_const_valid` is 0 and the next instruction starts at A+4.
- R4: While `bundle_valid` is 1 and `bundle_ready` is 0, `bundle_valid` stays 1 and every bundle output holds its value.
- R5: Opcode 6'h3E begins a loop. Its iteration count is source 0 bits [9:2], from 1 up to 255. The loop body runs exactly that many times.
- R6: A loop-begin with a count of 0 continues at the address held in word-0 bits [31:20] of the loop-begin instruction. No part of the loop body is presented.
- R7: Opcode 6'h3F ends a loop. It decrements the counter and branches back to the instruction that follows the loop-begin while the decremented count is nonzero. Neither loop opcode is presented on the bundle port.
- R8: Word-0 bit 19 marks the last instruction. `done` rises after that bundle is accepted and stays at 1, with no memory reads and no bundles, until the next `start`.
- R9: `depth_cfg` drops to 0 once a presented instruction has destination register 1 with write-mask bit z set. Otherwise it stays 1. Every `start` sets it back to 1.
- R10: Each word is fetched by a single-cycle `mem_rd_en` pulse, and the data is taken from `mem_rdata` one cycle later. No read addresses a word outside the program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins fetching at address 0 |
| done | output | 1 | Program finished; held until next start |
| depth_cfg | output | 1 | 0 when the program writes depth, else 1 |
| mem_rd_en | output | 1 | Program memory read strobe |
| mem_addr | output | AW | Program memory word address |
| mem_rdata | input | 32 | Read data, one cycle after the strobe |
| bundle_valid | output | 1 | Bundle outputs hold an instruction |
| bundle_ready | input | 1 | Execute stage accepts the bundle |
| out_opcode | output | 6 | Operation code |
| out_dst | output | 5 | Destination register |
| out_wmask | output | 4 | Component write mask |
| out_attr | output | 4 | Interpolated input selector |
| out_src0 | output | 32 | Source 0 selector word |
| out_src1 | output | 32 | Source 1 selector word |
| out_src2 | output | 32 | Source 2 selector word |
| out_const_valid | output | 1 | An inline constant accompanies the bundle |
| out_const | output | 128 | Inline vec4 constant, component 0 in the low word |

## Verification
The hardest situations to reach are the loop edges combined with inline constants. Examples are a zero-count loop whose skip target depends on how many constant words the body contains, and a 255-iteration loop whose loop instructions carry their own constants. The program generator emits loop-begin first and patches its skip field once the matching loop-end has been laid down, so every skip address is correct whatever constants appear. Directed programs cover counts 0 and 255. Random programs mix constant density, depth writes and loop shapes. Throughout, `bundle_ready` is dropped at random so that bundles are held while loops are in flight.

// File: rtl/frag_fetch_pkg.sv
package frag_fetch_pkg;

  localparam int DATA_W = 32;
  localparam int SKIP_W = 12;

  localparam logic [5:0] OPC_LOOP_BEGIN = 6'h3E;
  localparam logic [5:0] OPC_LOOP_END   = 6'h3F;
  localparam logic [1:0] SRC_KIND_CONST = 2'b10;
  localparam logic [4:0] DEPTH_REG      = 5'd1;
  localparam int         MASK_Z_BIT     = 2;

  typedef struct packed {
    logic [SKIP_W-1:0] skip;
    logic              last;
    logic [3:0]        attr;
    logic [3:0]        wmask;
    logic [4:0]        dst;
    logic [5:0]        opc;
  } word0_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_CAPT,
    ST_DECIDE,
    ST_PRESENT
  } ffs_state_e;

endpackage

// File: rtl/ffs_word_asm.sv
module ffs_word_asm
  import frag_fetch_pkg::*;
#(
  parameter int INSN_WORDS  = 4,
  parameter int CONST_WORDS = 4,
  localparam int IDX_W      = $clog2(INSN_WORDS + CONST_WORDS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cap_en,
  input  logic [IDX_W-1:0]                cap_idx,
  input  logic [DATA_W-1:0]               rdata,
  output logic                            need_const_live,
  output logic                            const_have,
  output logic [INSN_WORDS*DATA_W-1:0]    insn_flat,
  output logic [CONST_WORDS*DATA_W-1:0]   const_flat
);

  logic [DATA_W-1:0] iw_q [INSN_WORDS];
  logic [DATA_W-1:0] iw_d [INSN_WORDS];
  logic [DATA_W-1:0] cw_q [CONST_WORDS];
  logic [DATA_W-1:0] cw_d [CONST_WORDS];
  logic              have_q, have_d;

  // constant detection: stored middle selectors plus the last selector arriving now
  always_comb begin
    need_const_live = 1'b0;
    for (int s = 1; s < INSN_WORDS - 1; s++) begin
      if (iw_q[s][1:0] == SRC_KIND_CONST) need_const_live = 1'b1;
    end
    if (rdata[1:0] == SRC_KIND_CONST) need_const_live = 1'b1;
  end

  always_comb begin
    for (int i = 0; i < INSN_WORDS; i++) begin
      iw_d[i] = iw_q[i];
      if (cap_en && (cap_idx == IDX_W'(i))) iw_d[i] = rdata;
    end
    for (int k = 0; k < CONST_WORDS; k++) begin
      cw_d[k] = cw_q[k];
      if (cap_en && (cap_idx == IDX_W'(INSN_WORDS + k))) cw_d[k] = rdata;
    end
    have_d = have_q;
    if (cap_en && (cap_idx == '0))                      have_d = 1'b0;
    if (cap_en && (cap_idx == IDX_W'(INSN_WORDS - 1)))  have_d = need_const_live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < INSN_WORDS; i++)  iw_q[i] <= '0;
      for (int k = 0; k < CONST_WORDS; k++) cw_q[k] <= '0;
      have_q <= 1'b0;
    end else begin
      for (int i = 0; i < INSN_WORDS; i++)  iw_q[i] <= iw_d[i];
      for (int k = 0; k < CONST_WORDS; k++) cw_q[k] <= cw_d[k];
      have_q <= have_d;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < INSN_WORDS; gi++) begin : g_insn_out
      assign insn_flat[gi*DATA_W +: DATA_W] = iw_q[gi];
    end
    for (gi = 0; gi < CONST_WORDS; gi++) begin : g_const_out
      assign const_flat[gi*DATA_W +: DATA_W] = have_q ? cw_q[gi] : '0;
    end
  endgenerate

  assign const_have = have_q;

endmodule

// File: rtl/ffs_loop_unit.sv
module ffs_loop_unit #(
  parameter int AW     = 12,
  parameter int LOOP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load_en,
  input  logic [LOOP_W-1:0] load_cnt,
  input  logic [AW-1:0]     load_ret,
  input  logic              step_en,
  output logic              take_back,
  output logic [AW-1:0]     ret_addr
);

  logic [LOOP_W-1:0] cnt_q, cnt_d;
  logic [AW-1:0]     ret_q, ret_d;

  always_comb begin
    cnt_d = cnt_q;
    ret_d = ret_q;
    if (clr) begin
      cnt_d = '0;
    end else if (load_en) begin
      cnt_d = load_cnt;
      ret_d = load_ret;
    end else if (step_en && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ret_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      ret_q <= ret_d;
    end
  end

  assign take_back = (cnt_q > LOOP_W'(1));
  assign ret_addr  = ret_q;

  // R7
  loop_cnt_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load_en) |=> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/ffs_ctrl.sv
module ffs_ctrl
  import frag_fetch_pkg::*;
#(
  parameter int AW          = 12,
  parameter int LOOP_W      = 8,
  parameter int INSN_WORDS  = 4,
  parameter int CONST_WORDS = 4,
  localparam int IDX_W      = $clog2(INSN_WORDS + CONST_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              bundle_ready,
  input  word0_t            w0,
  input  logic [DATA_W-1:0] src0_word,
  input  logic              const_have,
  input  logic              need_const_live,
  input  logic              take_back,
  input  logic [AW-1:0]     ret_addr,
  output logic              mem_rd_en,
  output logic [AW-1:0]     mem_addr,
  output logic              cap_en,
  output logic [IDX_W-1:0]  cap_idx,
  output logic              bundle_valid,
  output logic              done,
  output logic              depth_cfg,
  output logic              loop_clr,
  output logic              loop_load,
  output logic [LOOP_W-1:0] loop_cnt,
  output logic [AW-1:0]     loop_ret,
  output logic              loop_step
);

  localparam logic [IDX_W-1:0] LAST_INSN_IDX  = IDX_W'(INSN_WORDS - 1);
  localparam logic [IDX_W-1:0] LAST_CONST_IDX = IDX_W'(INSN_WORDS + CONST_WORDS - 1);
  localparam logic [AW-1:0]    LEN_PLAIN      = AW'(INSN_WORDS);
  localparam logic [AW-1:0]    LEN_WITH_CONST = AW'(INSN_WORDS + CONST_WORDS);

  ffs_state_e        st_q, st_d;
  logic [AW-1:0]     pc_q, pc_d;
  logic [IDX_W-1:0]  widx_q, widx_d;
  logic              done_q, done_d;
  logic              depth_q, depth_d;
  logic [AW-1:0]     next_pc;
  logic              finish;

  assign next_pc  = pc_q + (const_have ? LEN_WITH_CONST : LEN_PLAIN);
  assign loop_cnt = src0_word[2 +: LOOP_W];
  assign loop_ret = next_pc;

  always_comb begin
    st_d      = st_q;
    pc_d      = pc_q;
    widx_d    = widx_q;
    done_d    = done_q;
    depth_d   = depth_q;
    mem_rd_en = 1'b0;
    cap_en    = 1'b0;
    bundle_valid = 1'b0;
    loop_clr  = 1'b0;
    loop_load = 1'b0;
    loop_step = 1'b0;
    finish    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          pc_d     = '0;
          widx_d   = '0;
          done_d   = 1'b0;
          depth_d  = 1'b1;
          loop_clr = 1'b1;
          st_d     = ST_REQ;
        end
      end
      ST_REQ: begin
        mem_rd_en = 1'b1;
        st_d      = ST_CAPT;
      end
      ST_CAPT: begin
        cap_en = 1'b1;
        if (((widx_q == LAST_INSN_IDX) && !need_const_live) ||
            (widx_q == LAST_CONST_IDX)) begin
          st_d = ST_DECIDE;
        end else begin
          widx_d = widx_q + 1'b1;
          st_d   = ST_REQ;
        end
      end
      ST_DECIDE: begin
        widx_d = '0;
        if (w0.opc == OPC_LOOP_BEGIN) begin
          if (loop_cnt == '0) begin
            pc_d = AW'(w0.skip);
          end else begin
            loop_load = 1'b1;
            pc_d      = next_pc;
          end
          finish = w0.last;
          st_d   = finish ? ST_IDLE : ST_REQ;
        end else if (w0.opc == OPC_LOOP_END) begin
          loop_step = 1'b1;
          pc_d      = take_back ? ret_addr : next_pc;
          finish    = w0.last && !take_back;
          st_d      = finish ? ST_IDLE : ST_REQ;
        end else begin
          if ((w0.dst == DEPTH_REG) && w0.wmask[MASK_Z_BIT]) depth_d = 1'b0;
          st_d = ST_PRESENT;
        end
        if (finish) done_d = 1'b1;
      end
      ST_PRESENT: begin
        bundle_valid = 1'b1;
        if (bundle_ready) begin
          if (w0.last) begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            pc_d = next_pc;
            st_d = ST_REQ;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      pc_q    <= '0;
      widx_q  <= '0;
      done_q  <= 1'b0;
      depth_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      pc_q    <= pc_d;
      widx_q  <= widx_d;
      done_q  <= done_d;
      depth_q <= depth_d;
    end
  end

  assign mem_addr  = pc_q + AW'(widx_q);
  assign cap_idx   = widx_q;
  assign done      = done_q;
  assign depth_cfg = depth_q;

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_rd_en && !bundle_valid));

  // R4
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bundle_valid && !bundle_ready) |=> bundle_valid);

  // R9
  depth_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(depth_cfg) |-> $past(start && (st_q == ST_IDLE)));

  // R10
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

endmodule

// File: rtl/frag_fetch_seq.sv
module frag_fetch_seq
  import frag_fetch_pkg::*;
#(
  parameter int AW          = 12,
  parameter int LOOP_W      = 8,
  parameter int INSN_WORDS  = 4,
  parameter int CONST_WORDS = 4,
  localparam int IDX_W      = $clog2(INSN_WORDS + CONST_WORDS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  output logic                          done,
  output logic                          depth_cfg,
  output logic                          mem_rd_en,
  output logic [AW-1:0]                 mem_addr,
  input  logic [DATA_W-1:0]             mem_rdata,
  output logic                          bundle_valid,
  input  logic                          bundle_ready,
  output logic [5:0]                    out_opcode,
  output logic [4:0]                    out_dst,
  output logic [3:0]                    out_wmask,
  output logic [3:0]                    out_attr,
  output logic [DATA_W-1:0]             out_src0,
  output logic [DATA_W-1:0]             out_src1,
  output logic [DATA_W-1:0]             out_src2,
  output logic                          out_const_valid,
  output logic [CONST_WORDS*DATA_W-1:0] out_const
);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic                          cap_en;
  logic [IDX_W-1:0]              cap_idx;
  logic                          need_const_live;
  logic                          const_have;
  logic [INSN_WORDS*DATA_W-1:0]  insn_flat;
  logic                          loop_clr, loop_load, loop_step, take_back;
  logic [LOOP_W-1:0]             loop_cnt;
  logic [AW-1:0]                 loop_ret, ret_addr;
  word0_t                        w0;

  assign w0 = word0_t'(insn_flat[DATA_W-1:0]);

  ffs_word_asm #(
    .INSN_WORDS  (INSN_WORDS),
    .CONST_WORDS (CONST_WORDS)
  ) u_asm (
    .clk             (clk),
    .rst_n           (rst_core_n),
    .cap_en          (cap_en),
    .cap_idx         (cap_idx),
    .rdata           (mem_rdata),
    .need_const_live (need_const_live),
    .const_have      (const_have),
    .insn_flat       (insn_flat),
    .const_flat      (out_const)
  );

  ffs_loop_unit #(
    .AW     (AW),
    .LOOP_W (LOOP_W)
  ) u_loop (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .clr       (loop_clr),
    .load_en   (loop_load),
    .load_cnt  (loop_cnt),
    .load_ret  (loop_ret),
    .step_en   (loop_step),
    .take_back (take_back),
    .ret_addr  (ret_addr)
  );

  ffs_ctrl #(
    .AW          (AW),
    .LOOP_W      (LOOP_W),
    .INSN_WORDS  (INSN_WORDS),
    .CONST_WORDS (CONST_WORDS)
  ) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_core_n),
    .start           (start),
    .bundle_ready    (bundle_ready),
    .w0              (w0),
    .src0_word       (insn_flat[DATA_W +: DATA_W]),
    .const_have      (const_have),
    .need_const_live (need_const_live),
    .take_back       (take_back),
    .ret_addr        (ret_addr),
    .mem_rd_en       (mem_rd_en),
    .mem_addr        (mem_addr),
    .cap_en          (cap_en),
    .cap_idx         (cap_idx),
    .bundle_valid    (bundle_valid),
    .done            (done),
    .depth_cfg       (depth_cfg),
    .loop_clr        (loop_clr),
    .loop_load       (loop_load),
    .loop_cnt        (loop_cnt),
    .loop_ret        (loop_ret),
    .loop_step       (loop_step)
  );

  assign out_opcode      = w0.opc;
  assign out_dst         = w0.dst;
  assign out_wmask       = w0.wmask;
  assign out_attr        = w0.attr;
  assign out_src0        = insn_flat[1*DATA_W +: DATA_W];
  assign out_src1        = insn_flat[2*DATA_W +: DATA_W];
  assign out_src2        = insn_flat[3*DATA_W +: DATA_W];
  assign out_const_valid = const_have;

  // R4
  bundle_stable_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bundle_valid && !bundle_ready) |=>
      ($stable(out_opcode) && $stable(out_dst) && $stable(out_wmask) &&
       $stable(out_attr) && $stable(out_src0) && $stable(out_src1) &&
       $stable(out_src2) && $stable(out_const_valid) && $stable(out_const)));

endmodule

// File: tb/frag_fetch_seq_tb.sv
`timescale 1ns/1ps
module frag_fetch_seq_tb;

  localparam int BW = 6 + 5 + 4 + 4 + 96 + 1 + 128;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic         done, depth_cfg, mem_rd_en, bundle_valid, bundle_ready;
  logic [11:0]  mem_addr;
  logic [31:0]  mem_rdata;
  logic [5:0]   out_opcode;
  logic [4:0]   out_dst;
  logic [3:0]   out_wmask, out_attr;
  logic [31:0]  out_src0, out_src1, out_src2;
  logic         out_const_valid;
  logic [127:0] out_const;

  always #2 clk = ~clk;

  frag_fetch_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .depth_cfg(depth_cfg),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .bundle_valid(bundle_valid), .bundle_ready(bundle_ready),
    .out_opcode(out_opcode), .out_dst(out_dst), .out_wmask(out_wmask),
    .out_attr(out_attr), .out_src0(out_src0), .out_src1(out_src1),
    .out_src2(out_src2), .out_const_valid(out_const_valid), .out_const(out_const)
  );

  logic [31:0]   mem [0:1023];
  logic [BW-1:0] exp_b [0:1023];
  int            exp_n, exp_depth, wp, p_const, bad_reads;
  int            n_cmp = 0, n_bad = 0, cyc_total = 0;
  wire [BW-1:0]  cur = {out_opcode, out_dst, out_wmask, out_attr, out_src0,
                        out_src1, out_src2, out_const_valid, out_const};

  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr[9:0]];

  always @(posedge clk) if (mem_rd_en && (int'(mem_addr) >= wp)) bad_reads++;

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired act=%0d exp<=150000", cyc_total);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                     input logic [255:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_w0(input logic [5:0] opc, input logic [4:0] dst,
      input logic [3:0] msk, input logic [3:0] attr, input logic last, input logic [11:0] skip);
    return {skip, last, attr, msk, dst, opc};
  endfunction

  function automatic logic [31:0] rnd_src();
    logic [1:0] kind;
    kind = (($urandom % 100) < p_const) ? 2'b10 : ((($urandom % 2) == 0) ? 2'b00 : 2'b01);
    return {$urandom, 2'b00} | {30'd0, kind};
  endfunction

  task automatic emit(input logic [31:0] w0, input logic [31:0] s0,
                      input logic [31:0] s1, input logic [31:0] s2);
    mem[wp] = w0; mem[wp+1] = s0; mem[wp+2] = s1; mem[wp+3] = s2;
    wp += 4;
    if (s0[1:0] == 2'b10 || s1[1:0] == 2'b10 || s2[1:0] == 2'b10) begin
      for (int k = 0; k < 4; k++) mem[wp+k] = $urandom;
      wp += 4;
    end
  endtask

  task automatic emit_plain(input logic last);
    emit(mk_w0(6'($urandom % 62), 5'($urandom % 6), 4'($urandom), 4'($urandom), last, 12'd0),
         rnd_src(), rnd_src(), rnd_src());
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 32'hDEAD_BEEF;
    wp = 0;
  endtask

  // kind 0: straight line; kind 1: one loop, cnt < 0 means random 1..6
  task automatic gen_prog(input int kind, input int cnt, input int body);
    int rep_at, c;
    clear_mem();
    if (kind == 0) begin
      int n = 1 + $urandom % 6;
      for (int i = 0; i < n; i++) emit_plain(i == n - 1);
    end else begin
      int pre = $urandom % 3;
      for (int i = 0; i < pre; i++) emit_plain(1'b0);
      c = (cnt < 0) ? 1 + $urandom % 6 : cnt;
      rep_at = wp;
      emit(mk_w0(6'h3E, 5'd0, 4'd0, 4'd0, 1'b0, 12'd0),
           {22'd0, 8'(c), 2'b00}, rnd_src(), rnd_src());
      for (int i = 0; i < body; i++) emit_plain(1'b0);
      emit(mk_w0(6'h3F, 5'd0, 4'd0, 4'd0, 1'b0, 12'd0), rnd_src(), rnd_src(), rnd_src());
      mem[rep_at][31:20] = 12'(wp);
      emit_plain(1'b0);
      emit_plain(1'b1);
    end
  endtask

  task automatic model_run();
    int pc = 0, lc = 0, ls = 0, len;
    logic [31:0] w0, s0, s1, s2;
    logic cv, tb;
    exp_n = 0; exp_depth = 1;
    for (int steps = 0; steps < 4000; steps++) begin
      w0 = mem[pc]; s0 = mem[pc+1]; s1 = mem[pc+2]; s2 = mem[pc+3];
      cv = (s0[1:0] == 2'b10) || (s1[1:0] == 2'b10) || (s2[1:0] == 2'b10);
      len = cv ? 8 : 4;
      if (w0[5:0] == 6'h3E) begin
        if (s0[9:2] == 8'd0) pc = int'(w0[31:20]);
        else begin lc = int'(s0[9:2]); ls = pc + len; pc = pc + len; end
        if (w0[19]) break;
      end else if (w0[5:0] == 6'h3F) begin
        tb = (lc > 1);
        if (lc != 0) lc--;
        pc = tb ? ls : pc + len;
        if (w0[19] && !tb) break;
      end else begin
        exp_b[exp_n] = {w0[5:0], w0[10:6], w0[14:11], w0[18:15], s0, s1, s2, cv,
                        cv ? {mem[pc+7], mem[pc+6], mem[pc+5], mem[pc+4]} : 128'd0};
        exp_n++;
        if (w0[10:6] == 5'd1 && w0[13]) exp_depth = 0;
        pc = pc + len;
        if (w0[19]) break;
      end
    end
  endtask

  task automatic run_prog(input string tag);
    int idx = 0, cyc = 0;
    bit held = 0, r;
    logic [BW-1:0] snap;
    model_run();
    bad_reads = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (done) break;
      if (held) chk(bundle_valid && (cur == snap), {"R4 held bundle ", tag}, 256'(cur), 256'(snap));
      held = 0;
      if (bundle_valid) begin
        r = ($urandom % 4) != 0;
        bundle_ready = r;
        if (r) begin
          if (idx < exp_n) chk(cur == exp_b[idx], {"R2 R3 bundle ", tag}, 256'(cur), 256'(exp_b[idx]));
          else chk(1'b0, {"R8 extra bundle ", tag}, 256'(idx), 256'(exp_n));
          idx++;
        end else begin
          held = 1; snap = cur;
        end
      end else begin
        bundle_ready = 1'($urandom % 2);
      end
    end
    chk(done == 1'b1, {"R8 done reached ", tag}, 256'(done), 256'(1));
    chk(idx == exp_n, {"R2 bundle count ", tag}, 256'(idx), 256'(exp_n));
    chk(int'(depth_cfg) == exp_depth, {"R9 depth flag ", tag}, 256'(depth_cfg), 256'(exp_depth));
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      bundle_ready = 1'b1;
      if (mem_rd_en || bundle_valid || !done) begin
        chk(1'b0, {"R8 quiet after done ", tag}, 256'({mem_rd_en, bundle_valid, done}), 256'(3'b001));
        break;
      end
    end
    chk(bad_reads == 0, {"R10 reads in range ", tag}, 256'(bad_reads), 256'(0));
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    rst_n = 1'b0; start = 1'b0; bundle_ready = 1'b0; p_const = 30; wp = 0;
    clear_mem();
    repeat (3) @(negedge clk);
    chk(!mem_rd_en && !bundle_valid && !done && depth_cfg, "R1 in reset",
        256'({mem_rd_en, bundle_valid, done, depth_cfg}), 256'(4'b0001));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!mem_rd_en && !bundle_valid && !done && depth_cfg, "R1 after reset",
        256'({mem_rd_en, bundle_valid, done, depth_cfg}), 256'(4'b0001));

    // R9: depth write, then a program that only nearly writes depth
    clear_mem();
    emit(mk_w0(6'h05, 5'd1, 4'b0100, 4'd3, 1'b1, 12'd0), rnd_src(), rnd_src(), rnd_src());
    run_prog("R9 write");
    clear_mem();
    emit(mk_w0(6'h07, 5'd1, 4'b1011, 4'd0, 1'b0, 12'd0), rnd_src(), rnd_src(), rnd_src());
    emit(mk_w0(6'h07, 5'd0, 4'b0100, 4'd0, 1'b1, 12'd0), rnd_src(), rnd_src(), rnd_src());
    run_prog("R9 no write");

    // R3: heavy constant use
    p_const = 70;
    gen_prog(0, 0, 0); run_prog("R3 consts");
    p_const = 0;
    gen_prog(0, 0, 0); run_prog("R3 none");
    p_const = 30;

    // R6: count zero skip; R5: maximum count
    gen_prog(1, 0, 2);   run_prog("R6 zero count");
    gen_prog(1, 255, 1); run_prog("R5 count 255");
    gen_prog(1, 1, 3);   run_prog("R7 count 1");

    for (int t = 0; t < 24; t++) begin
      p_const = $urandom % 80;
      if (t % 3 == 0) begin gen_prog(0, 0, 0); run_prog("R2 random straight"); end
      else begin gen_prog(1, -1, 1 + $urandom % 3); run_prog("R7 random loop"); end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule